// File: doc/BRIEF.md
# GPIO Bank with Mirrored Output Paths

This block controls a bank of up to 32 general-purpose pins through a simple word-addressed register port. Every pin owns a main control word, which sets direction, drive type, pull, power gating, input pad disable, input-change detection and the output level. It also owns an auxiliary word that is kept only as storage for pad drive settings. Two bank-wide registers group the pins bit by bit: a parallel output register and a parallel input register. A third bank register holds the sticky per-pin detection status, which is also brought out on a port.

Each pin holds its output level in exactly one flop. Software sees that flop through two views: bit 16 of the control word and the pin's bit in the parallel output register. A per-pin write-select bit decides which view accepts writes. Firmware can therefore set up a pin completely through its control word and then hand the level over to the parallel register without disturbing the pad. Input-change detection runs on the synchronized pad input, and only while the input pad is enabled and the pin is powered.

Top module: `gpio_mirror_bank`

## Requirements
- R1: After reset every register reads 0 (while pad inputs are low), and every pad output enable and detection status bit is 0. Reads return data on `rdata` one cycle after `rd_en`. Address map: `addr[6:5]`=0 selects control word `addr[4:0]`; 1 selects auxiliary word `addr[4:0]`; 2 selects a bank register. In the bank region, `addr[1:0]`=0 is parallel out, 1 is parallel in and 2 is status.
- R2: The output level reads back identically as control bit 16 and as bit n of the parallel output register. Pad outputs follow a register change one clock later.
- R3: The write-select bit is control bit 7. While it is 0, control bit 16 is writable and parallel output writes are ignored. While it is 1, the parallel bit is writable and control bit 16 is ignored on write.
- R4: A control write that changes the write-select bit never changes the stored output level. Writability is judged on the select value before the write and after it.
- R5: The direction bit (bit 0, 1 = output) drives the pad output enable of a powered push-pull pin.
- R6: Buffer bit 1 set selects open drain. The output enable is then high only while the level is 0, and the open-drain pad flag is high.
- R7: The pull field (bits 3:2) appears on the pin's two-bit pull output: 00 none, 01 up, 10 down, 11 repeater.
- R8: Power field (bits 5:4) equal to 11 is off. The output enable is forced low, and the input reads 0 both in the parallel input register and in control bit 24.
- R9: A pin driving its output still samples its input. Control bit 24 and parallel input bit n show the two-stage-synchronized pad value.
- R10: The detection mode (bits 10:8) is 0 off, 1 level high, 2 level low, 3 rising, 4 falling or 5 both edges. An event sets a sticky status bit, and writing 1 to it clears it. A level condition that persists sets it again.
- R11: While the input pad disable bit (bit 6) is set, no detection event is raised in any mode, and the input reads 0.
- R12: Pins absent from VALID_MASK ignore writes, read 0, and never drive or raise status.
- R13: The auxiliary word stores and returns the written 32-bit value and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pad_in | input | NPINS | Pad input values |
| pad_out | output | NPINS | Pad output level |
| pad_oe | output | NPINS | Pad output enable |
| pad_od | output | NPINS | Open-drain mode per pin |
| pad_pull | output | 2*NPINS | Pull code, pin n at bits 2n+1:2n |
| irq_status | output | NPINS | Sticky detection status |

## Verification
The output flop is shared by two views. If it were ever duplicated or updated through the wrong view, the pad level would differ from one readback or the other within one cycle of the offending write. The bench writes through each view with each select value and checks the pad and both readbacks. A detector armed while its pad is disabled would show a status bit two to three cycles after a pad toggle, so gated pins are toggled and their status is watched. Stale synchronizer or previous-value state shows up as a missing or spurious edge event, which the rise, fall and clear sequences expose.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;
  localparam int DW = 32;

  // control word bit positions
  localparam int B_DIR   = 0;
  localparam int B_OD    = 1;
  localparam int B_PULL  = 2;   // 2 bits
  localparam int B_PWR   = 4;   // 2 bits
  localparam int B_PDIS  = 6;
  localparam int B_OSEL  = 7;
  localparam int B_DET   = 8;   // 3 bits
  localparam int B_LVL   = 16;
  localparam int B_INV   = 24;

  localparam logic [1:0] PWR_OFF = 2'b11;

  typedef enum logic [2:0] {
    DET_OFF  = 3'd0,
    DET_HIGH = 3'd1,
    DET_LOW  = 3'd2,
    DET_RISE = 3'd3,
    DET_FALL = 3'd4,
    DET_BOTH = 3'd5
  } det_mode_e;

  typedef enum logic [1:0] {
    RGN_CTRL = 2'd0,
    RGN_AUX  = 2'd1,
    RGN_BANK = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  typedef struct packed {
    logic [2:0] det;
    logic       osel;
    logic       pdis;
    logic [1:0] pwr;
    logic [1:0] pull;
    logic       od;
    logic       dir;
  } pin_cfg_t;

  function automatic pin_cfg_t unpack_cfg(logic [DW-1:0] w);
    pin_cfg_t c;
    c.dir  = w[B_DIR];
    c.od   = w[B_OD];
    c.pull = w[B_PULL+:2];
    c.pwr  = w[B_PWR+:2];
    c.pdis = w[B_PDIS];
    c.osel = w[B_OSEL];
    c.det  = w[B_DET+:3];
    return c;
  endfunction

  function automatic logic [DW-1:0] pack_cfg(pin_cfg_t c, logic lvl, logic inv);
    logic [DW-1:0] w;
    w = '0;
    w[B_DIR]    = c.dir;
    w[B_OD]     = c.od;
    w[B_PULL+:2] = c.pull;
    w[B_PWR+:2]  = c.pwr;
    w[B_PDIS]   = c.pdis;
    w[B_OSEL]   = c.osel;
    w[B_DET+:3] = c.det;
    w[B_LVL]    = lvl;
    w[B_INV]    = inv;
    return w;
  endfunction
endpackage

// File: rtl/gpio_mb_detect.sv
module gpio_mb_detect
  import gpio_mb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pad_in,
  input  logic       active,
  input  logic [2:0] mode,
  output logic       in_sync,
  output logic       hit
);
  localparam int SN = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SN-1:0] sync_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SN-2:0], pad_in};
      prev_q <= sync_q[SN-1];
    end
  end

  assign in_sync = sync_q[SN-1];

  logic raw_hit;
  always_comb begin
    case (mode)
      DET_HIGH: raw_hit = in_sync;
      DET_LOW:  raw_hit = ~in_sync;
      DET_RISE: raw_hit = in_sync & ~prev_q;
      DET_FALL: raw_hit = ~in_sync & prev_q;
      DET_BOTH: raw_hit = in_sync ^ prev_q;
      default:  raw_hit = 1'b0;
    endcase
  end

  assign hit = raw_hit & active;
endmodule

// File: rtl/gpio_mb_pin.sv
module gpio_mb_pin
  import gpio_mb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic          aux_we,
  input  logic [DW-1:0] wdata,
  input  logic          par_we,
  input  logic          par_bit,
  input  logic          sts_clr,
  input  logic          pad_in,
  output logic [DW-1:0] ctrl_rd,
  output logic [DW-1:0] aux_rd,
  output logic          lvl,
  output logic          in_eff,
  output logic          osel,
  output logic          pdis,
  output logic          pwr_on,
  output logic          pad_out,
  output logic          pad_oe,
  output logic          pad_od,
  output logic [1:0]    pad_pull,
  output logic          sts
);
  pin_cfg_t      cfg_q;
  pin_cfg_t      cfg_nx;
  logic          lvl_q;
  logic [DW-1:0] aux_q;
  logic          in_sync;
  logic          det_hit;

  assign cfg_nx = unpack_cfg(wdata);

  // single output flop, two write views
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      lvl_q <= 1'b0;
    end else if (ctrl_we) begin
      cfg_q <= cfg_nx;
      if (!cfg_q.osel && !cfg_nx.osel) lvl_q <= wdata[B_LVL];
    end else if (par_we && cfg_q.osel) begin
      lvl_q <= par_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         aux_q <= '0;
    else if (aux_we) aux_q <= wdata;
  end

  assign pwr_on = (cfg_q.pwr != PWR_OFF);
  assign in_eff = in_sync & ~cfg_q.pdis & pwr_on;

  gpio_mb_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk     (clk),
    .rst     (rst),
    .pad_in  (pad_in),
    .active  (~cfg_q.pdis & pwr_on),
    .mode    (cfg_q.det),
    .in_sync (in_sync),
    .hit     (det_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) sts <= 1'b0;
    else     sts <= (sts & ~sts_clr) | det_hit;
  end

  // registered pad side
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out  <= 1'b0;
      pad_oe   <= 1'b0;
      pad_od   <= 1'b0;
      pad_pull <= 2'b00;
    end else begin
      pad_out  <= lvl_q;
      pad_oe   <= cfg_q.dir & pwr_on & (~cfg_q.od | ~lvl_q);
      pad_od   <= cfg_q.od;
      pad_pull <= cfg_q.pull;
    end
  end

  assign ctrl_rd = pack_cfg(cfg_q, lvl_q, in_eff);
  assign aux_rd  = aux_q;
  assign lvl     = lvl_q;
  assign osel    = cfg_q.osel;
  assign pdis    = cfg_q.pdis;
endmodule

// File: rtl/gpio_mirror_bank.sv
module gpio_mirror_bank
  import gpio_mb_pkg::*;
#(
  parameter int          NPINS       = 32,
  parameter int          ADDR_W      = 7,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] VALID_MASK  = 32'h7FFF_FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_od,
  output logic [2*NPINS-1:0]   pad_pull,
  output logic [NPINS-1:0]     irq_status
);
  localparam logic [NPINS-1:0] VMASK = VALID_MASK[NPINS-1:0];
  localparam logic [1:0] BK_POUT = 2'd0;
  localparam logic [1:0] BK_PIN  = 2'd1;
  localparam logic [1:0] BK_STS  = 2'd2;

  region_e    rgn;
  logic [4:0] idx;
  logic [1:0] bk_sel;
  assign rgn    = region_e'(addr[6:5]);
  assign idx    = addr[4:0];
  assign bk_sel = addr[1:0];

  logic par_we;
  logic sts_we;
  assign par_we = wr_en && (rgn == RGN_BANK) && (bk_sel == BK_POUT);
  assign sts_we = wr_en && (rgn == RGN_BANK) && (bk_sel == BK_STS);

  logic [DW-1:0]    ctrl_rd [NPINS];
  logic [DW-1:0]    aux_rd  [NPINS];
  logic [NPINS-1:0] lvl_v, in_v, osel_v, dis_v, pwr_on_v;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (VMASK[i]) begin : g_on
      gpio_mb_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (wr_en && (rgn == RGN_CTRL) && (idx == 5'(i))),
        .aux_we   (wr_en && (rgn == RGN_AUX) && (idx == 5'(i))),
        .wdata    (wdata),
        .par_we   (par_we),
        .par_bit  (wdata[i]),
        .sts_clr  (sts_we && wdata[i]),
        .pad_in   (pad_in[i]),
        .ctrl_rd  (ctrl_rd[i]),
        .aux_rd   (aux_rd[i]),
        .lvl      (lvl_v[i]),
        .in_eff   (in_v[i]),
        .osel     (osel_v[i]),
        .pdis     (dis_v[i]),
        .pwr_on   (pwr_on_v[i]),
        .pad_out  (pad_out[i]),
        .pad_oe   (pad_oe[i]),
        .pad_od   (pad_od[i]),
        .pad_pull (pad_pull[2*i+:2]),
        .sts      (irq_status[i])
      );
    end else begin : g_off
      logic unused_pad;
      assign unused_pad       = pad_in[i];
      assign ctrl_rd[i]       = '0;
      assign aux_rd[i]        = '0;
      assign lvl_v[i]         = 1'b0;
      assign in_v[i]          = 1'b0;
      assign osel_v[i]        = 1'b0;
      assign dis_v[i]         = 1'b0;
      assign pwr_on_v[i]      = 1'b0;
      assign pad_out[i]       = 1'b0;
      assign pad_oe[i]        = 1'b0;
      assign pad_od[i]        = 1'b0;
      assign pad_pull[2*i+:2] = 2'b00;
      assign irq_status[i]    = 1'b0;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rgn)
      RGN_CTRL: if (32'(idx) < NPINS) rd_mux = ctrl_rd[idx];
      RGN_AUX:  if (32'(idx) < NPINS) rd_mux = aux_rd[idx];
      RGN_BANK: begin
        case (bk_sel)
          BK_POUT: rd_mux[NPINS-1:0] = lvl_v;
          BK_PIN:  rd_mux[NPINS-1:0] = in_v;
          BK_STS:  rd_mux[NPINS-1:0] = irq_status;
          default: rd_mux = '0;
        endcase
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  logic unused_misc;
  assign unused_misc = ^{addr[ADDR_W-1:5], addr[4:2], osel_v, dis_v, pwr_on_v};
endmodule

// File: rtl/gpio_mirror_bank_chk.sv
module gpio_mirror_bank_chk #(
  parameter int          NPINS      = 32,
  parameter int          ADDR_W     = 7,
  parameter logic [31:0] VALID_MASK = 32'h7FFF_FFFF
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_od,
  input logic [NPINS-1:0]  irq_status,
  input logic [NPINS-1:0]  lvl_v,
  input logic [NPINS-1:0]  osel_v,
  input logic [NPINS-1:0]  dis_v,
  input logic [NPINS-1:0]  pwr_on_v
);
  localparam logic [NPINS-1:0]  VMASK    = VALID_MASK[NPINS-1:0];
  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(66);

  assert_od_low_only_R6: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_od & pad_out) == '0);

  assert_select_keeps_level_R4: assert property (@(posedge clk) disable iff (rst)
    ((osel_v ^ $past(osel_v)) & (lvl_v ^ $past(lvl_v))) == '0);

  assert_gated_detect_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_status & ~$past(irq_status) & $past(dis_v)) == '0);

  assert_off_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~$past(pwr_on_v)) == '0);

  assert_unimpl_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | irq_status) & ~VMASK) == '0);

  assert_sticky_status_R10: assert property (@(posedge clk) disable iff (rst)
    ((~irq_status & $past(irq_status)) != '0) |-> $past(wr_en && (addr == STS_ADDR)));
endmodule

bind gpio_mirror_bank gpio_mirror_bank_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .irq_status(irq_status),
  .lvl_v(lvl_v), .osel_v(osel_v), .dis_v(dis_v), .pwr_on_v(pwr_on_v)
);

// File: tb/gpio_mirror_bank_tb.sv
module gpio_mirror_bank_tb;
  localparam int NP = 32;
  localparam logic [6:0] A_POUT = 7'd64;
  localparam logic [6:0] A_PIN  = 7'd65;
  localparam logic [6:0] A_STS  = 7'd66;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pad_od, irq_status;
  logic [2*NP-1:0] pad_pull;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mirror_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_od(pad_od), .pad_pull(pad_pull), .irq_status(irq_status)
  );

  function automatic logic [31:0] mk(logic dir, logic od, logic [1:0] pull, logic [1:0] pwr,
                                     logic dis, logic osel, logic [2:0] det, logic lvl);
    logic [31:0] w;
    w = '0;
    w[0] = dir; w[1] = od; w[3:2] = pull; w[5:4] = pwr;
    w[6] = dis; w[7] = osel; w[10:8] = det; w[16] = lvl;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(7'd0, d);  chk("R1 ctrl0", d, 0);
    rd(A_POUT, d); chk("R1 pout", d, 0);
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 irq", 32'(irq_status), 0);
  endtask

  task automatic t_aux();
    logic [31:0] d;
    wr(7'd32 + 7'd3, 32'hA5C3_1E0F);
    rd(7'd32 + 7'd3, d); chk("R13 aux", d, 32'hA5C3_1E0F);
    chk("R13 no pad effect", 32'(pad_oe[3]), 0);
  endtask

  task automatic t_ctrl_path();
    logic [31:0] d;
    wr(7'd1, mk(1, 0, 0, 0, 0, 0, 0, 1));
    chk("R5 oe", 32'(pad_oe[1]), 1);
    chk("R2 out", 32'(pad_out[1]), 1);
    rd(A_POUT, d); chk("R2 mirror", 32'(d[1]), 1);
    wr(A_POUT, 32'h0);
    rd(7'd1, d); chk("R3 par ignored", 32'(d[16]), 1);
    chk("R3 pad kept", 32'(pad_out[1]), 1);
  endtask

  task automatic t_switch();
    logic [31:0] d;
    wr(7'd1, mk(1, 0, 0, 0, 0, 1, 0, 0));
    chk("R4 switch to par keeps level", 32'(pad_out[1]), 1);
    wr(A_POUT, 32'h0);
    chk("R3 par write", 32'(pad_out[1]), 0);
    rd(7'd1, d); chk("R2 ctrl mirror", 32'(d[16]), 0);
    chk("R3 osel readback", 32'(d[7]), 1);
    wr(7'd1, mk(1, 0, 0, 0, 0, 1, 0, 1));
    chk("R3 ctrl ignored", 32'(pad_out[1]), 0);
    wr(7'd1, mk(1, 0, 0, 0, 0, 0, 0, 1));
    chk("R4 switch back keeps level", 32'(pad_out[1]), 0);
    wr(7'd1, mk(1, 0, 0, 0, 0, 0, 0, 1));
    chk("R3 ctrl writable again", 32'(pad_out[1]), 1);
  endtask

  task automatic t_open_drain();
    wr(7'd2, mk(1, 1, 0, 0, 0, 0, 0, 1));
    chk("R6 od high no drive", 32'(pad_oe[2]), 0);
    chk("R6 od flag", 32'(pad_od[2]), 1);
    wr(7'd2, mk(1, 1, 0, 0, 0, 0, 0, 0));
    chk("R6 od low drives", 32'(pad_oe[2]), 1);
  endtask

  task automatic t_pull();
    wr(7'd3, mk(0, 0, 2'b11, 0, 0, 0, 0, 0));
    chk("R7 repeater", 32'(pad_pull[7:6]), 3);
    wr(7'd3, mk(0, 0, 2'b10, 0, 0, 0, 0, 0));
    chk("R7 pulldown", 32'(pad_pull[7:6]), 2);
  endtask

  task automatic t_power();
    logic [31:0] d;
    pad_in[8] = 1'b1;
    wr(7'd8, mk(1, 0, 0, 2'b11, 0, 0, 0, 1));
    settle();
    chk("R8 off no oe", 32'(pad_oe[8]), 0);
    rd(A_PIN, d); chk("R8 off pin", 32'(d[8]), 0);
    rd(7'd8, d); chk("R8 off ctrl in", 32'(d[24]), 0);
    wr(7'd8, mk(1, 0, 0, 2'b00, 0, 0, 0, 1));
    chk("R8 on oe", 32'(pad_oe[8]), 1);
    rd(A_PIN, d); chk("R9 on pin", 32'(d[8]), 1);
  endtask

  task automatic t_in_out();
    logic [31:0] d;
    wr(7'd4, mk(1, 0, 0, 0, 0, 0, 0, 0));
    pad_in[4] = 1'b1; settle();
    rd(A_PIN, d); chk("R9 par in", 32'(d[4]), 1);
    rd(7'd4, d); chk("R9 ctrl in", 32'(d[24]), 1);
    chk("R9 still driving", 32'(pad_oe[4]), 1);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(7'd5, mk(0, 0, 0, 0, 0, 0, 3'd3, 0));
    chk("R10 idle", 32'(irq_status[5]), 0);
    pad_in[5] = 1'b1; settle();
    rd(A_STS, d); chk("R10 rise set", 32'(d[5]), 1);
    wr(A_STS, 32'h1 << 5);
    chk("R10 w1c", 32'(irq_status[5]), 0);
    pad_in[5] = 1'b0; settle();
    chk("R10 fall ignored in rise mode", 32'(irq_status[5]), 0);
    wr(7'd5, mk(0, 0, 0, 0, 0, 0, 3'd4, 0));
    pad_in[5] = 1'b1; settle();
    chk("R10 rise ignored in fall mode", 32'(irq_status[5]), 0);
    pad_in[5] = 1'b0; settle();
    chk("R10 fall set", 32'(irq_status[5]), 1);
  endtask

  task automatic t_gated();
    logic [31:0] d;
    wr(7'd6, mk(0, 0, 0, 0, 1, 0, 3'd5, 0));
    pad_in[6] = 1'b1; settle();
    rd(A_PIN, d); chk("R11 in gated", 32'(d[6]), 0);
    pad_in[6] = 1'b0; settle();
    chk("R11 no event", 32'(irq_status[6]), 0);
    wr(7'd6, mk(0, 0, 0, 0, 0, 0, 3'd5, 0));
    pad_in[6] = 1'b1; settle();
    chk("R11 enabled event", 32'(irq_status[6]), 1);
  endtask

  task automatic t_level();
    wr(7'd7, mk(0, 0, 0, 0, 0, 0, 3'd1, 0));
    pad_in[7] = 1'b1; settle();
    chk("R10 level high", 32'(irq_status[7]), 1);
    wr(A_STS, 32'h1 << 7);
    chk("R10 level re-set", 32'(irq_status[7]), 1);
    wr(7'd9, mk(0, 0, 0, 0, 0, 0, 3'd2, 0));
    settle();
    chk("R10 level low", 32'(irq_status[9]), 1);
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    wr(7'd31, mk(1, 0, 2'b01, 0, 0, 0, 3'd2, 1));
    settle();
    chk("R12 no oe", 32'(pad_oe[31]), 0);
    chk("R12 no irq", 32'(irq_status[31]), 0);
    rd(7'd31, d); chk("R12 ctrl reads 0", d, 0);
    wr(7'd32 + 7'd31, 32'hFFFF_FFFF);
    rd(7'd32 + 7'd31, d); chk("R12 aux reads 0", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aux();
    t_ctrl_path();
    t_switch();
    t_open_drain();
    t_pull();
    t_power();
    t_in_out();
    t_edge();
    t_gated();
    t_level();
    t_invalid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule